// File: doc/BRIEF.md
# Synchronous Byte Shifter

The block is a synchronous serial port that moves one byte out on a serial output and one byte in from a serial input per transfer. Both bytes share a single data register: the outgoing byte shifts out of one end while the incoming bits shift in at the other. When all eight bits have moved, the data register holds the received byte. Software programs a mode register and sets its start bit to launch a transfer. The shift clock comes from one of three internal divided clocks, which the block can drive onto the clock pin, or from an external pin that the block synchronises into the system clock domain.

A transfer starts on the next falling edge of the selected shift clock after the start bit is set. Outgoing data changes on falling edges and incoming data is sampled on rising edges. On the eighth rising edge the start bit clears itself and a sticky completion flag is set. The interrupt request is a level: it is high while that flag and the interrupt enable are both set. If software clears the start bit in the same cycle as completion, the transfer is abandoned and the flag stays clear. While stopped with output enabled, the serial output already presents the first bit that will be sent. An external master therefore sees valid data before its first clock edge.

Top module: `sync_byte_shifter`

## Requirements
- R1: After reset the mode register reads 0x00, the data register reads 0x00, the shift clock output is high, and the interrupt request is low. Mode bit positions are: bit0 start, bit1 output enable, bits 3:2 clock select, bit4 clock-pin drive enable, bit5 LSB-first, bit6 done flag, bit7 interrupt enable.
- R2: Clock select 00, 01 and 10 give an internal shift clock with periods of 2, 8 and 32 system clocks. Clock select 11 uses the external clock input. The clock-pin enable output is high only when bit4 is set and an internal clock is selected.
- R3: The shift clock output is high whenever the start bit is clear.
- R4: After the start bit is set, the first falling edge of the internal shift clock appears on the pin within one shift-clock period: at least 1 and at most 2, 8 or 32 system clocks.
- R5: A transfer takes exactly 8 rising edges. The serial output changes only after falling edges and the serial input is sampled at rising edges. MSB-first (bit5 = 0) sends bit7 first and places the first received bit in bit7. LSB-first sends bit0 first and places the first received bit in bit0.
- R6: At completion the start bit reads 0, the flag reads 1, and the data register holds the received byte.
- R7: While the start bit is clear with output enabled (bit1 = 1), the serial output equals data bit7 when MSB-first is selected and data bit0 when LSB-first is selected. With output disabled the serial output is high.
- R8: A mode write with start = 0 that lands in the same cycle as completion leaves the flag at 0 and the start bit at 0.
- R9: The flag stays set until a mode write with bit6 = 0 clears it. Writing 1 to bit6 has no effect. The interrupt request equals flag AND bit7.
- R10: While the start bit is set, data register writes are ignored, and mode writes do not change bits 7 and 5:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWe | input | 1 | Mode register write strobe |
| modeWdata | input | 8 | Mode register write value |
| dataWe | input | 1 | Data register write strobe |
| dataWdata | input | 8 | Data register write value |
| modeQ | output | 8 | Mode register contents |
| dataQ | output | 8 | Data register contents |
| sin | input | 1 | Serial data input |
| sclkIn | input | 1 | External shift clock input |
| sclkOut | output | 1 | Shift clock drive value |
| sclkOe | output | 1 | Shift clock pin drive enable |
| sout | output | 1 | Serial data output |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check four properties on every cycle. The clock pin is high while the port is stopped. The configuration bits stay unchanged while a transfer is active. The flag rises only together with the start bit falling. The flag persists unless a clearing write arrives. Only the bench scenarios can show the actual bit order on the wire, the received byte, the shift-clock period and start latency for each divider, the one-cycle stop/complete race, and the first-bit presentation in external mode. These are exercised by a full sweep of byte values at the fastest divider plus targeted transfers at the slower dividers and with the external clock.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int MODE_W   = 8;
  localparam int B_START  = 0;
  localparam int B_SOE    = 1;
  localparam int B_CKS_LO = 2;
  localparam int B_CKS_HI = 3;
  localparam int B_SCKOE  = 4;
  localparam int B_LSB    = 5;
  localparam int B_FLAG   = 6;
  localparam int B_IRQEN  = 7;
  localparam logic [1:0] CKS_EXT = 2'b11;

  typedef struct packed {
    logic shift;   // falling edge inside a transfer: move to next bit
    logic sample;  // rising edge: capture the serial input
    logic finish;  // eighth rising edge: final shift with live input
  } shiftStrobe_t;
endpackage

// File: rtl/shift_clk_gen.sv
module shift_clk_gen #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cks,
  input  logic       sclkIn,
  output logic       fallEvt,
  output logic       riseEvt,
  output logic       sclkLevel
);
  localparam int CNT_W = $clog2(DIV_C / 2) + 1;
  localparam logic [CNT_W-1:0] HALF_A = CNT_W'(DIV_A / 2 - 1);
  localparam logic [CNT_W-1:0] HALF_B = CNT_W'(DIV_B / 2 - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DIV_C / 2 - 1);

  logic [CNT_W-1:0] cnt, halfM1;
  logic tick, sclkInt, extMode;
  logic [SYNC_STAGES:0] syncQ;
  logic extCur, extPrev;

  always_comb begin
    case (cks)
      2'b00:   halfM1 = HALF_A;
      2'b01:   halfM1 = HALF_B;
      default: halfM1 = HALF_C;
    endcase
  end

  assign tick = (cnt >= halfM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      sclkInt <= 1'b1;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) sclkInt <= ~sclkInt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], sclkIn};
  end

  assign extCur  = syncQ[SYNC_STAGES-1];
  assign extPrev = syncQ[SYNC_STAGES];
  assign extMode = (cks == shift_pkg::CKS_EXT);

  assign fallEvt   = extMode ? (extPrev & ~extCur) : (tick & sclkInt);
  assign riseEvt   = extMode ? (~extPrev & extCur) : (tick & ~sclkInt);
  assign sclkLevel = sclkInt;
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modeWe,
  input  logic [shift_pkg::MODE_W-1:0]  modeWdata,
  input  logic                          dataWe,
  input  logic                          fallEvt,
  input  logic                          riseEvt,
  output logic [shift_pkg::MODE_W-1:0]  modeQ,
  output logic                          running,
  output logic                          dataLoad,
  output shift_pkg::shiftStrobe_t       strb
);
  import shift_pkg::*;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [MODE_W-1:0] modeR;
  logic [CNT_W-1:0]  bitCnt;
  logic active, stopReq, kick, flagNext;

  assign active  = modeR[B_START];
  assign stopReq = modeWe & ~modeWdata[B_START];
  assign kick    = active & ~running & fallEvt & ~stopReq;

  always_comb begin
    strb.shift  = active & running & fallEvt & ~stopReq;
    strb.sample = active & running & riseEvt & ~stopReq;
    strb.finish = strb.sample & (bitCnt == LAST_BIT);
  end

  always_comb begin
    flagNext = modeR[B_FLAG];
    if (modeWe && !modeWdata[B_FLAG]) flagNext = 1'b0;
    if (strb.finish)                  flagNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR   <= '0;
      running <= 1'b0;
      bitCnt  <= '0;
    end else begin
      modeR[B_FLAG] <= flagNext;
      if (!active) begin
        running <= 1'b0;
        bitCnt  <= '0;
        if (modeWe) begin
          modeR[B_START]           <= modeWdata[B_START];
          modeR[B_SOE]             <= modeWdata[B_SOE];
          modeR[B_CKS_HI:B_CKS_LO] <= modeWdata[B_CKS_HI:B_CKS_LO];
          modeR[B_SCKOE]           <= modeWdata[B_SCKOE];
          modeR[B_LSB]             <= modeWdata[B_LSB];
          modeR[B_IRQEN]           <= modeWdata[B_IRQEN];
        end
      end else if (stopReq || strb.finish) begin
        modeR[B_START] <= 1'b0;
        running        <= 1'b0;
        bitCnt         <= '0;
      end else begin
        if (kick)        running <= 1'b1;
        if (strb.sample) bitCnt  <= bitCnt + 1'b1;
      end
    end
  end

  assign modeQ    = modeR;
  assign dataLoad = dataWe & ~active;
endmodule

// File: rtl/shift_data.sv
module shift_data #(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  shift_pkg::shiftStrobe_t strb,
  input  logic                    dataLoad,
  input  logic [DATA_W-1:0]       dataWdata,
  input  logic                    lsbFirst,
  input  logic                    soe,
  input  logic                    sin,
  output logic [DATA_W-1:0]       dataQ,
  output logic                    sout
);
  logic [DATA_W-1:0] dataR;
  logic inBit;

  function automatic logic [DATA_W-1:0] pushBit(input logic [DATA_W-1:0] d,
                                               input logic b, input logic lsb);
    return lsb ? {b, d[DATA_W-1:1]} : {d[DATA_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataR <= '0;
      inBit <= 1'b0;
    end else begin
      if (strb.sample) inBit <= sin;
      if (dataLoad)         dataR <= dataWdata;
      else if (strb.finish) dataR <= pushBit(dataR, sin, lsbFirst);
      else if (strb.shift)  dataR <= pushBit(dataR, inBit, lsbFirst);
    end
  end

  assign dataQ = dataR;
  assign sout  = soe ? (lsbFirst ? dataR[0] : dataR[DATA_W-1]) : 1'b1;
endmodule

// File: rtl/sync_byte_shifter.sv
module sync_byte_shifter #(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 8,
  parameter int DIV_C  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [7:0]        modeWdata,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataWdata,
  output logic [7:0]        modeQ,
  output logic [DATA_W-1:0] dataQ,
  input  logic              sin,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              sout,
  output logic              irq
);
  import shift_pkg::*;
  logic fallEvt, riseEvt, sclkLevel, running, dataLoad, extMode;
  shiftStrobe_t strb;

  shift_clk_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SYNC_STAGES(2)) uClk (
    .clk(clk), .rstN(rstN), .cks(modeQ[B_CKS_HI:B_CKS_LO]), .sclkIn(sclkIn),
    .fallEvt(fallEvt), .riseEvt(riseEvt), .sclkLevel(sclkLevel));

  shift_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWdata(modeWdata), .dataWe(dataWe),
    .fallEvt(fallEvt), .riseEvt(riseEvt), .modeQ(modeQ), .running(running),
    .dataLoad(dataLoad), .strb(strb));

  shift_data #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dataLoad(dataLoad), .dataWdata(dataWdata),
    .lsbFirst(modeQ[B_LSB]), .soe(modeQ[B_SOE]), .sin(sin), .dataQ(dataQ), .sout(sout));

  assign extMode = (modeQ[B_CKS_HI:B_CKS_LO] == CKS_EXT);
  assign sclkOut = ~(running & ~extMode) | sclkLevel;
  assign sclkOe  = modeQ[B_SCKOE] & ~extMode;
  assign irq     = modeQ[B_FLAG] & modeQ[B_IRQEN];
endmodule

// File: rtl/shift_checker.sv
module shift_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] modeQ,
  input logic       modeWe,
  input logic [7:0] modeWdata,
  input logic       sclkOut
);
  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ[0] |-> sclkOut); // R3

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    modeQ[0] |=> (modeQ[5:1] == $past(modeQ[5:1]) && modeQ[7] == $past(modeQ[7]))); // R10

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeQ[6]) |-> $fell(modeQ[0])); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[6] && !(modeWe && !modeWdata[6])) |=> modeQ[6]); // R9
endmodule

bind sync_byte_shifter shift_checker uChk (
  .clk(clk), .rstN(rstN), .modeQ(modeQ), .modeWe(modeWe),
  .modeWdata(modeWdata), .sclkOut(sclkOut));

// File: tb/tb_sync_byte_shifter.sv
`timescale 1ns/1ps
module tb_sync_byte_shifter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWe = 1'b0, dataWe = 1'b0, sin = 1'b0, sclkIn = 1'b1;
  logic [7:0] modeWdata = '0, dataWdata = '0;
  logic [7:0] modeQ, dataQ;
  logic sclkOut, sclkOe, sout, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sync_byte_shifter dut (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWdata(modeWdata), .dataWe(dataWe),
    .dataWdata(dataWdata), .modeQ(modeQ), .dataQ(dataQ), .sin(sin), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .sout(sout), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrMode(input logic [7:0] v);
    modeWe = 1'b1; modeWdata = v;
    @(negedge clk);
    modeWe = 1'b0;
  endtask

  task automatic wrData(input logic [7:0] v);
    dataWe = 1'b1; dataWdata = v;
    @(negedge clk);
    dataWe = 1'b0;
  endtask

  // Internal-clock transfer; bench acts as the peripheral on the wire.
  task automatic intXfer(input logic [1:0] cks, input bit lsb, input logic [7:0] tx,
                         input logic [7:0] rx, input bit meddle);
    logic [7:0] cfg, gotByte;
    logic prev, cur, lastOut;
    int t, nIn, nOut, firstFall, secondFall, divv;
    divv = (cks == 2'd0) ? 2 : (cks == 2'd1) ? 8 : 32;
    cfg = {1'b1, 1'b0, lsb, 1'b1, cks, 1'b1, 1'b0};
    wrMode(cfg);
    wrData(tx);
    wrMode(cfg | 8'h01);
    prev = 1'b1; lastOut = 1'b0; gotByte = '0;
    t = 0; nIn = 0; nOut = 0; firstFall = -1; secondFall = -1;
    while (1) begin
      if (meddle && t == 20) begin
        dataWe = 1'b1; dataWdata = ~tx;
        modeWe = 1'b1; modeWdata = (cfg ^ 8'h3E) | 8'h41;
      end else if (meddle && t == 21) begin
        dataWe = 1'b0; modeWe = 1'b0;
      end
      cur = sclkOut;
      if (prev && !cur) begin
        if (firstFall < 0) firstFall = t;
        else if (secondFall < 0) secondFall = t;
        sin = lsb ? rx[nIn % 8] : rx[7 - (nIn % 8)];
        nIn++;
      end
      if (!prev && cur) begin
        gotByte = lsb ? {lastOut, gotByte[7:1]} : {gotByte[6:0], lastOut};
        nOut++;
      end
      if (!cur) lastOut = sout;
      prev = cur;
      if (!modeQ[0] || t > 2000) break;
      @(negedge clk);
      t++;
    end
    chk(firstFall >= 1 && firstFall <= divv, "R4 start latency", firstFall, divv);
    chk(secondFall - firstFall == divv, "R2 shift clock period", secondFall - firstFall, divv);
    chk(nOut == 8, "R5 rising edges per byte", nOut, 8);
    chk(gotByte == tx, "R5 bits seen on serial out", gotByte, tx);
    chk(dataQ == rx, "R6 received byte", dataQ, rx);
    chk(modeQ[6] == 1'b1 && modeQ[0] == 1'b0, "R6 flag set start clear", modeQ, 8'h40);
    chk(irq == 1'b1, "R9 irq with enable", irq, 1);
    if (meddle)
      chk(modeQ[5:1] == cfg[5:1] && modeQ[7] == cfg[7], "R10 config held", modeQ, cfg);
  endtask

  // External-clock transfer; optional stop in the completion cycle.
  task automatic extXfer(input bit lsb, input logic [7:0] tx, input logic [7:0] rx,
                         input bit race);
    logic [7:0] cfg, gotByte;
    cfg = {1'b1, 1'b0, lsb, 1'b1, 2'b11, 1'b1, 1'b0};
    gotByte = '0;
    wrMode(cfg);
    wrData(tx);
    chk(sclkOe == 1'b0, "R2 no clock drive in external mode", sclkOe, 0);
    chk(sout == (lsb ? tx[0] : tx[7]), "R7 first bit while stopped", sout, lsb ? tx[0] : tx[7]);
    wrMode(cfg | 8'h01);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      sclkIn = 1'b0;
      sin = lsb ? rx[k] : rx[7 - k];
      repeat (8) @(negedge clk);
      gotByte = lsb ? {sout, gotByte[7:1]} : {gotByte[6:0], sout};
      sclkIn = 1'b1;
      if (k == 7 && race) begin
        @(negedge clk);
        @(negedge clk);
        wrMode(cfg | 8'h40);
      end else begin
        repeat (8) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    chk(modeQ[0] == 1'b0, "R6 start cleared", modeQ[0], 0);
    if (race) begin
      chk(modeQ[6] == 1'b0, "R8 flag suppressed by stop", modeQ[6], 0);
      chk(irq == 1'b0, "R8 no irq after race", irq, 0);
    end else begin
      chk(gotByte == tx, "R5 external bits out", gotByte, tx);
      chk(dataQ == rx, "R6 external received byte", dataQ, rx);
      chk(modeQ[6] == 1'b1, "R6 external flag", modeQ[6], 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(modeQ == 8'h00, "R1 mode reset", modeQ, 0);
    chk(dataQ == 8'h00, "R1 data reset", dataQ, 0);
    chk(sclkOut == 1'b1, "R1 clock high", sclkOut, 1);
    chk(irq == 1'b0, "R1 irq low", irq, 0);

    // Stopped: output-enable off drives high; on shows first bit.
    wrData(8'h01);
    chk(sout == 1'b1, "R7 output disabled high", sout, 1);
    wrMode(8'h02);
    chk(sout == 1'b0, "R7 msb shown", sout, 0);
    wrMode(8'h22);
    chk(sout == 1'b1, "R7 lsb shown", sout, 1);
    wrMode(8'h12);
    chk(sclkOe == 1'b1 && sclkOut == 1'b1, "R3 idle clock driven high", {sclkOe, sclkOut}, 3);

    // Full byte sweep at the fastest divider, both orders.
    for (int i = 0; i < 256; i++) begin
      intXfer(2'd0, i[0], 8'(i), 8'((i * 37 + 11) & 8'hFF), 1'b0);
      chk(sclkOut == 1'b1, "R3 clock high after transfer", sclkOut, 1);
    end
    for (int i = 0; i < 12; i++)
      intXfer(2'd1, i[0], 8'(i * 23 + 5), 8'(8'hA5 ^ i), 1'b0);
    intXfer(2'd2, 1'b0, 8'h3C, 8'hC6, 1'b0);
    intXfer(2'd2, 1'b1, 8'h81, 8'h7E, 1'b1);

    // Flag behaviour.
    wrMode(8'hC0);
    chk(modeQ[6] == 1'b1 && irq == 1'b1, "R9 writing one keeps flag", modeQ, 8'hC0);
    wrMode(8'h40);
    chk(modeQ[6] == 1'b1 && irq == 1'b0, "R9 irq gated by enable", irq, 0);
    wrMode(8'h80);
    chk(modeQ[6] == 1'b0 && irq == 1'b0, "R9 writing zero clears flag", modeQ, 8'h80);

    // R10 data write ignored while waiting for first edge (external, no clock).
    wrMode(8'h0F);
    wrData(8'h55);
    chk(dataQ != 8'h55, "R10 data write ignored while started", dataQ, 8'h00);
    wrMode(8'h0E);

    extXfer(1'b0, 8'hB2, 8'h4D, 1'b0);
    extXfer(1'b1, 8'h6A, 8'hD1, 1'b0);
    extXfer(1'b0, 8'h0F, 8'hF0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule